// File: doc/BRIEF.md
# Serial Memory Slave Front End with Transfer Pause

This block is the bus-facing front end of a serial memory slave. It receives a four-wire serial bus made of clock, active-low select, data in and data out, plus an active-low pause input. All bus inputs are oversampled in the system clock domain through synchronizer chains. Bits are sampled on rising serial clock edges, most significant bit first. After every eighth bit the block hands the assembled byte to the command logic with a one-cycle strobe. Response bytes supplied by the command logic go out most significant bit first. Each response bit changes only after a falling serial clock edge. The block works whether the serial clock idles low (mode 0) or idles high (mode 3).

A small state machine sets the link state. It has three states: `ST_IDLE` (select high, output released), `ST_XFER` (select low, bits moving) and `ST_PAUSE` (transfer frozen, output released). The transitions are:
- `ST_IDLE` to `ST_XFER` when select falls. The first response byte is loaded at the same time.
- `ST_XFER` to `ST_PAUSE` when pause is low while the serial clock is low.
- `ST_PAUSE` to `ST_XFER` when pause is high while the serial clock is low.
- Either active state to `ST_IDLE` as soon as select is high, which clears the transfer.

A pause requested while the clock is high therefore takes effect at the next low clock. A release requested while the clock is high likewise waits for the next low clock. The bit position is kept across a pause.

Top module: `fsh_slave_if`

## Requirements
- R1: During and right after reset, `spi_miso_oe` and `rx_valid` are 0.
- R2: With select high the output enable is 0. Deselecting in the middle of a byte drops the partial byte (no `rx_valid`), and the next transfer starts again at bit position zero.
- R3: Data in is sampled on rising serial clock edges, first bit into the most significant position. After each eighth rising edge, `rx_valid` is high for exactly one system clock cycle, with `rx_data` holding the byte.
- R4: `spi_miso` shows the response byte most significant bit first. `tx_data` is captured when select falls and again at the first falling edge after each completed byte. The output bit changes only after falling edges.
- R5: R3 and R4 hold both with the clock idle low at select assertion (mode 0) and with the clock idle high (mode 3).
- R6: Pause low while the clock is low enters the pause state, and the output enable goes to 0. Pause going low while the clock is high has no effect until the clock next goes low.
- R7: While paused, clock and data-in activity is ignored. After the pause, bit counting continues from the same position, so no byte is corrupted or lost.
- R8: Pause high while the clock is low leaves the pause state, and the output is enabled again. A release while the clock is high keeps the pause until the clock next goes low.
- R9: Select going high during a pause returns the block to idle and clears the transfer. No byte is produced, and the next transfer starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low select; a falling edge starts a transfer |
| spi_mosi | input | 1 | Serial data in |
| spi_pause_n | input | 1 | Active-low pause request |
| tx_data | input | BYTE_W | Next response byte from the command logic |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_oe | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| rx_data | output | BYTE_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |

## Verification
The assertions assume the following about the bus inputs:
- Each serial clock phase lasts several system clock cycles longer than the synchronizer latency.
- Data in settles while the clock is low.
- `tx_data` is steady around the falling edge that loads it.

Under those conditions the assertions expect a pause to begin and end only on a low sampled clock, and no output bit to change outside the cycle after a falling edge. The stimulus keeps within these limits:
- Every clock phase is six system cycles long.
- Data in and the response byte are changed only mid-phase and mid-byte.
- Random pauses are placed both at low and at high clock phases, including a release made while the clock is high.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_PAUSE = 2'd2
    } link_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

endpackage

// File: rtl/fsh_sync.sv
module fsh_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fsh_ctrl.sv
module fsh_ctrl
    import fsh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_s,
    input  logic        cs_n_s,
    input  logic        pause_n_s,
    output link_state_t state,
    output sck_evt_t    evt,
    output logic        start,
    output logic        clear,
    output logic        out_en
);

    link_state_t nxt;
    logic        sck_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sck_q <= 1'b0;
        end else begin
            state <= nxt;
            sck_q <= sck_s;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!cs_n_s) nxt = ST_XFER;
            ST_XFER: begin
                if (cs_n_s)                      nxt = ST_IDLE;
                else if (!pause_n_s && !sck_s)   nxt = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (cs_n_s)                      nxt = ST_IDLE;
                else if (pause_n_s && !sck_s)    nxt = ST_XFER;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start    = 1'b0;
        clear    = cs_n_s;
        out_en   = 1'b0;
        evt      = '0;
        unique case (state)
            ST_IDLE:  start = !cs_n_s;
            ST_XFER: begin
                out_en   = 1'b1;
                evt.rise = !cs_n_s &&  sck_s && !sck_q;
                evt.fall = !cs_n_s && !sck_s &&  sck_q;
            end
            ST_PAUSE: out_en = 1'b0;
            default:  out_en = 1'b0;
        endcase
    end

    AST_PAUSE_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && $past(state) == ST_XFER) |-> !$past(sck_s)); // R6

    AST_PAUSE_EXIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && $past(state) == ST_PAUSE) |-> !$past(sck_s)); // R8

    AST_PAUSE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && cs_n_s) |=> state == ST_IDLE); // R9

endmodule

// File: rtl/fsh_rx.sv
module fsh_rx #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      rise,
    input  logic                      din,
    output logic [BYTE_W-1:0]         rx_data,
    output logic                      rx_valid,
    output logic                      byte_done,
    output logic [$clog2(BYTE_W)-1:0] bit_cnt
);

    localparam int                CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;

    assign byte_done = rise && (bit_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[BYTE_W-3:0], din};
                if (bit_cnt == LAST) begin
                    rx_data  <= {shreg, din};
                    rx_valid <= 1'b1;
                    bit_cnt  <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R3

endmodule

// File: rtl/fsh_tx.sv
module fsh_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clear,
    input  logic              rise,
    input  logic              fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] load_data,
    output logic              dout
);

    logic [BYTE_W-1:0] sh;
    logic              shift_pend;
    logic              load_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            shift_pend <= 1'b0;
            load_pend  <= 1'b0;
        end else if (start) begin
            sh         <= load_data;
            shift_pend <= 1'b0;
            load_pend  <= 1'b0;
        end else if (clear) begin
            shift_pend <= 1'b0;
            load_pend  <= 1'b0;
        end else begin
            if (rise) begin
                if (byte_done) load_pend  <= 1'b1;
                else           shift_pend <= 1'b1;
            end
            if (fall) begin
                if (load_pend) begin
                    sh        <= load_data;
                    load_pend <= 1'b0;
                end else if (shift_pend) begin
                    sh         <= {sh[BYTE_W-2:0], 1'b0};
                    shift_pend <= 1'b0;
                end
            end
        end
    end

    assign dout = sh[BYTE_W-1];

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_pend && load_pend)); // R4

endmodule

// File: rtl/fsh_slave_if.sv
module fsh_slave_if
    import fsh_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              spi_pause_n,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [3:0]       sync_q;
    logic             sck_s, cs_n_s, mosi_s, pause_n_s;
    link_state_t      state;
    sck_evt_t         evt;
    logic             start, clear, out_en, byte_done;
    logic [CNT_W-1:0] bit_cnt;
    logic             tx_bit;

    fsh_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_pause_n, spi_cs_n, spi_mosi, spi_sck}),
        .q     (sync_q)
    );

    assign {pause_n_s, cs_n_s, mosi_s, sck_s} = sync_q;

    fsh_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .cs_n_s    (cs_n_s),
        .pause_n_s (pause_n_s),
        .state     (state),
        .evt       (evt),
        .start     (start),
        .clear     (clear),
        .out_en    (out_en)
    );

    fsh_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .rise      (evt.rise),
        .din       (mosi_s),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .byte_done (byte_done),
        .bit_cnt   (bit_cnt)
    );

    fsh_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear     (clear),
        .rise      (evt.rise),
        .fall      (evt.fall),
        .byte_done (byte_done),
        .load_data (tx_data),
        .dout      (tx_bit)
    );

    assign spi_miso    = tx_bit;
    assign spi_miso_oe = out_en;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!spi_miso_oe && !rx_valid)); // R1

    AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !spi_miso_oe); // R2

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> bit_cnt == '0); // R2

    AST_VALID_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state) == ST_XFER); // R3

    AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && !$past(evt.fall)) |-> $stable(spi_miso)); // R4

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && $past(state) == ST_PAUSE) |-> $stable(bit_cnt)); // R7

endmodule

// File: tb/fsh_slave_if_bench.sv
module fsh_slave_if_bench;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_pause_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       spi_miso, spi_miso_oe, rx_valid;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    fsh_slave_if u_fsh_slave_if (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_pause_n (spi_pause_n),
        .tx_data     (tx_data),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid)
    );

    int         n_run = 0;
    int         n_fail = 0;
    int         rx_cnt = 0;
    bit         done = 1'b0;
    logic [7:0] rx_log [256];
    logic [7:0] mo [4];
    logic [7:0] rs [4];

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_log[rx_cnt % 256] = rx_data;
            rx_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected output bit computed from the response byte, MSB first
    function automatic logic exp_bit(input logic [7:0] b, input int i);
        return b[i];
    endfunction

    // hm: 0 none, 1 pause entered and left while clock low, 2 entered and released while clock high
    task automatic bit_step(input logic d, input logic e, input int hm);
        if (hm == 2) begin
            spi_pause_n = 1'b0; wt(H);
            check(spi_miso_oe === 1'b1, "R6 entry deferred while clock high", spi_miso_oe, 1);
            spi_sck = 1'b0; wt(H);
            check(spi_miso_oe === 1'b0, "R6 entry at next low clock", spi_miso_oe, 0);
            spi_sck = 1'b1; spi_mosi = ~d; wt(H);
            spi_pause_n = 1'b1; wt(H);
            check(spi_miso_oe === 1'b0, "R8 release deferred while clock high", spi_miso_oe, 0);
            spi_sck = 1'b0; wt(H);
        end else begin
            spi_sck = 1'b0;
        end
        spi_mosi = d; wt(H);
        if (hm == 1) begin
            spi_pause_n = 1'b0; wt(H);
            check(spi_miso_oe === 1'b0, "R6 entry with clock low", spi_miso_oe, 0);
            spi_sck = 1'b1; spi_mosi = ~d; wt(H);
            spi_sck = 1'b0; wt(H);
            spi_pause_n = 1'b1; spi_mosi = d; wt(H);
            check(spi_miso_oe === 1'b1, "R8 exit with clock low", spi_miso_oe, 1);
        end
        check(spi_miso_oe === 1'b1 && spi_miso === e, "R4/R5 output bit",
              {30'd0, spi_miso_oe, spi_miso}, {30'd0, 1'b1, e});
        spi_sck = 1'b1; wt(H);
    endtask

    task automatic run_xfer(input bit m3, input int nb, input int hp);
        int base;
        int hm;
        spi_sck = m3; wt(2*H);
        tx_data = rs[0]; wt(2);
        spi_cs_n = 1'b0; wt(H);
        base = rx_cnt;
        for (int b = 0; b < nb; b++) begin
            for (int i = 7; i >= 0; i--) begin
                hm = 0;
                if (int'($urandom_range(99)) < hp)
                    hm = (spi_sck && $urandom_range(1) == 1) ? 2 : 1;
                bit_step(mo[b][i], exp_bit(rs[b], i), hm);
                if (i == 3 && b + 1 < nb) tx_data = rs[b+1];
            end
        end
        if (!m3) begin spi_sck = 1'b0; wt(H); end
        spi_cs_n = 1'b1; wt(2*H);
        check(spi_miso_oe === 1'b0, "R2 output released after deselect", spi_miso_oe, 0);
        check(rx_cnt - base == nb, "R3/R7 byte count", rx_cnt - base, nb);
        for (int b = 0; b < nb; b++)
            check(rx_log[(base + b) % 256] === mo[b], "R3/R5/R7 received byte",
                  rx_log[(base + b) % 256], mo[b]);
    endtask

    initial begin
        int base;
        void'($urandom(32'h5EED));
        wt(3);
        check(spi_miso_oe === 1'b0 && rx_valid === 1'b0, "R1 in reset", {spi_miso_oe, rx_valid}, 0);
        rst_n = 1'b1; wt(3);
        check(spi_miso_oe === 1'b0 && rx_valid === 1'b0, "R1 after reset", {spi_miso_oe, rx_valid}, 0);

        // directed: both clock modes, no pause
        mo[0] = 8'hA5; mo[1] = 8'h3C; rs[0] = 8'h81; rs[1] = 8'h7E;
        run_xfer(1'b0, 2, 0);
        mo[0] = 8'h5A; mo[1] = 8'hC3; rs[0] = 8'hF0; rs[1] = 8'h0F;
        run_xfer(1'b1, 2, 0);

        // directed pauses at every kind of position
        mo[0] = 8'h69; mo[1] = 8'h96; rs[0] = 8'hB2; rs[1] = 8'h4D;
        run_xfer(1'b0, 2, 60);
        mo[0] = 8'hE7; mo[1] = 8'h18; rs[0] = 8'h2B; rs[1] = 8'hD4;
        run_xfer(1'b1, 2, 60);

        // R2: partial byte dropped, next transfer aligned
        mo[0] = 8'hCA; rs[0] = 8'h93;
        spi_sck = 1'b0; tx_data = rs[0]; wt(2);
        spi_cs_n = 1'b0; wt(H);
        base = rx_cnt;
        for (int i = 7; i >= 5; i--) bit_step(mo[0][i], exp_bit(rs[0], i), 0);
        spi_sck = 1'b0; wt(H);
        spi_cs_n = 1'b1; wt(2*H);
        check(spi_miso_oe === 1'b0, "R2 tristate after mid-byte deselect", spi_miso_oe, 0);
        check(rx_cnt == base, "R2 partial byte dropped", rx_cnt - base, 0);
        mo[0] = 8'h1E; rs[0] = 8'hE1;
        run_xfer(1'b0, 1, 0);
        check(rx_log[(rx_cnt - 1) % 256] === 8'h1E, "R2 realigned after partial byte",
              rx_log[(rx_cnt - 1) % 256], 8'h1E);

        // R9: deselect during pause
        mo[0] = 8'h77; rs[0] = 8'h6C;
        spi_sck = 1'b1; tx_data = rs[0]; wt(2);
        spi_cs_n = 1'b0; wt(H);
        base = rx_cnt;
        for (int i = 7; i >= 3; i--) bit_step(mo[0][i], exp_bit(rs[0], i), 0);
        spi_sck = 1'b0; wt(H);
        spi_pause_n = 1'b0; wt(H);
        check(spi_miso_oe === 1'b0, "R6 paused before deselect", spi_miso_oe, 0);
        spi_cs_n = 1'b1; wt(H);
        spi_pause_n = 1'b1; wt(2*H);
        check(spi_miso_oe === 1'b0, "R9 idle after deselect in pause", spi_miso_oe, 0);
        check(rx_cnt == base, "R9 no byte from cleared transfer", rx_cnt - base, 0);
        mo[0] = 8'hB4; mo[1] = 8'h2D; rs[0] = 8'h55; rs[1] = 8'hAA;
        run_xfer(1'b1, 2, 0);
        check(rx_log[(rx_cnt - 2) % 256] === 8'hB4, "R9 clean restart",
              rx_log[(rx_cnt - 2) % 256], 8'hB4);

        // constrained random
        for (int t = 0; t < 40; t++) begin
            int nb;
            bit m3;
            m3 = 1'($urandom_range(1));
            nb = int'($urandom_range(4, 1));
            for (int b = 0; b < 4; b++) begin
                mo[b] = 8'($urandom);
                rs[b] = 8'($urandom);
            end
            run_xfer(m3, nb, int'($urandom_range(15)));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule